// File: doc/BRIEF.md
# Exact Dot-Product Long Accumulator

This block forms the scalar product of two vectors of single-precision numbers with no rounding at any step. Each element pair arrives as two words on a 64-bit operand bus, first the A element and then the B element. The unit multiplies the two 24-bit significands into a full 48-bit product. It places that product in a 640-bit two's-complement fixed-point register at a position set by the sum of the two exponents. It then adds the product when the signs agree and subtracts it when they differ. Software reads the exact sum back as ten 64-bit words. The result is bit-exact whatever the order of the terms, including when large terms cancel.

Three stages overlap. An operand fetch state machine spends two cycles on each word: an accept cycle and a decode cycle. A multiply/shift register holds the current pair. An accumulate state machine works on the earlier product, one cycle per sub-step. A carry or borrow that leaves the two words touched by a product is parked in a per-word flag. The flag is rippled upward one word at a time before the next product is taken and before `done` is raised.

Fetch states and transitions:
- F_WAIT_A → F_DEC_A on an accepted word.
- F_DEC_A → F_WAIT_B.
- F_WAIT_B → F_DEC_B on an accepted word.
- F_DEC_B → F_WAIT_A when the multiply stage takes the pair, otherwise → F_HOLD.
- F_HOLD → F_WAIT_A when the pair is taken.

Accumulate states and transitions:
- A_IDLE → A_RESOLVE while any flag is pending.
- A_IDLE → A_DECODE when a product is waiting and no flag is pending.
- A_DECODE → A_LOAD → A_ADDSUB → A_STORE → A_IDLE.
- A_RESOLVE → A_IDLE.

Asserting `clr` returns both machines to their first state.

Top module: `exact_dot_acc`

## Requirements
- R1: After reset every accumulator word reads zero, `done` is low and `in_ready` is high.
- R2: A word is accepted on a rising edge where `in_valid` and `in_ready` are both high, and `in_ready` is low in the following cycle (decode), so each word occupies at least two cycles.
- R3: Accepted words alternate: the first of a pair is A and the second is B. `in_last` is sampled with B and marks the final pair. Each operand is single precision in `in_data[31:0]` (sign bit 31, exponent bits 30:23, fraction bits 22:0), and `in_data[63:32]` is ignored.
- R4: Each pair contributes the integer (1.fa)·(1.fb), a 48-bit value, shifted left by ea+eb−2 bit positions. The contribution is added when bits 31 of A and B are equal and subtracted otherwise, modulo 2^640.
- R5: An operand whose exponent field is 0 counts as zero whatever its fraction, and its pair leaves the sum unchanged.
- R6: Carries and borrows out of the two words a product touches are held in at most one per-word flag at a time and propagated to higher words before `done`. A carry out of word 9 is discarded.
- R7: `done` rises after the last pair has been accumulated and all flags are resolved. It stays high until `clr` or the next accepted word, after which it is low in the following cycle.
- R8: A one-cycle `clr` empties the pipeline. In the next cycle all words read zero, all flags are clear and `done` is low, and nothing in flight before the clear reaches the accumulator.
- R9: `rd_data` returns word `rd_idx` combinationally, equal to bits [64k+63:64k] of the sum. An index of 10 or more returns zero.
- R10: The accumulate sub-steps run in the fixed order decode, load, add/subtract, store, one cycle each. For a single pair into an idle unit with no carry out, `done` rises on the seventh rising edge after the edge that accepted B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of accumulator, flags and pipeline |
| in_valid | input | 1 | Operand word present |
| in_ready | output | 1 | Unit can accept a word this cycle |
| in_data | input | 64 | Operand word, single-precision value in the low 32 bits |
| in_last | input | 1 | With B: this pair is the final one |
| done | output | 1 | Sum complete and carries resolved |
| rd_idx | input | 4 | Accumulator word index for readout |
| rd_data | output | 64 | Selected accumulator word |

## Verification
The hardest case to reach from the ports is a borrow that has to ripple through many words, followed by a carry that ripples back through the same all-ones words and out of the top. It is reached by first subtracting the smallest normal product from a zero accumulator, which turns words 2 to 9 into all ones. A product of 1.0 is then added high in the register. Products at the largest exponents, with mixed signs, drive a carry into the highest flagged word. A pair that cancels an earlier one exactly checks a return to an all-zero sum.

// File: rtl/dpa_pkg.sv
`timescale 1ns/1ps
package dpa_pkg;

    localparam int FP_W    = 32;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int MANT_W  = FRAC_W + 1;
    localparam int PROD_W  = 2 * MANT_W;
    localparam int SHIFT_W = EXP_W + 1;

    typedef enum logic [2:0] {
        F_WAIT_A,
        F_DEC_A,
        F_WAIT_B,
        F_DEC_B,
        F_HOLD
    } fetch_st_t;

    typedef enum logic [2:0] {
        A_IDLE,
        A_DECODE,
        A_LOAD,
        A_ADDSUB,
        A_STORE,
        A_RESOLVE
    } acc_st_t;

    // One aligned product waiting for the accumulator
    typedef struct packed {
        logic               neg;
        logic               last;
        logic [SHIFT_W-1:0] shift;
        logic [PROD_W-1:0]  prod;
    } term_t;

    // Significand with hidden bit; zero exponent field means zero
    function automatic logic [MANT_W-1:0] signif(input logic [FP_W-1:0] w);
        return (w[FP_W-2 -: EXP_W] == '0) ? '0 : {1'b1, w[FRAC_W-1:0]};
    endfunction

endpackage

// File: rtl/dpa_fetch.sv
`timescale 1ns/1ps
module dpa_fetch
    import dpa_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              pair_valid,
    output logic [FP_W-1:0]   a_word,
    output logic [FP_W-1:0]   b_word,
    output logic              pair_last,
    input  logic              pair_take
);

    fetch_st_t       st_q, st_d;
    logic [FP_W-1:0] a_q, b_q;
    logic            last_q;
    logic            unused_hi;

    assign unused_hi = ^in_data[WORD_W-1:FP_W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st_q <= F_WAIT_A;
        else if (clr) st_q <= F_WAIT_A;
        else          st_q <= st_d;
    end

    // operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            last_q <= 1'b0;
        end else if (!clr) begin
            if (st_q == F_WAIT_A && in_valid) a_q <= in_data[FP_W-1:0];
            if (st_q == F_WAIT_B && in_valid) begin
                b_q    <= in_data[FP_W-1:0];
                last_q <= in_last;
            end
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            F_WAIT_A: if (in_valid) st_d = F_DEC_A;
            F_DEC_A:  st_d = F_WAIT_B;
            F_WAIT_B: if (in_valid) st_d = F_DEC_B;
            F_DEC_B:  st_d = pair_take ? F_WAIT_A : F_HOLD;
            F_HOLD:   if (pair_take) st_d = F_WAIT_A;
            default:  st_d = F_WAIT_A;
        endcase
    end

    // outputs
    always_comb begin
        in_ready   = (st_q == F_WAIT_A) || (st_q == F_WAIT_B);
        pair_valid = (st_q == F_DEC_B) || (st_q == F_HOLD);
        a_word     = a_q;
        b_word     = b_q;
        pair_last  = last_q;
    end

endmodule

// File: rtl/dpa_mulshift.sv
`timescale 1ns/1ps
module dpa_mulshift
    import dpa_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            in_valid,
    input  logic [FP_W-1:0] a_word,
    input  logic [FP_W-1:0] b_word,
    input  logic            in_last,
    output logic            in_take,
    output logic            out_valid,
    output term_t           out_term,
    input  logic            out_take
);

    logic             vld_q;
    term_t            term_q, term_d;
    logic [EXP_W-1:0] ea, eb;
    logic             zero;

    always_comb begin
        ea             = a_word[FP_W-2 -: EXP_W];
        eb             = b_word[FP_W-2 -: EXP_W];
        zero           = (ea == '0) || (eb == '0);
        term_d.neg     = a_word[FP_W-1] ^ b_word[FP_W-1];
        term_d.last    = in_last;
        term_d.shift   = zero ? '0 : ({1'b0, ea} + {1'b0, eb} - SHIFT_W'(2));
        term_d.prod    = PROD_W'(signif(a_word)) * PROD_W'(signif(b_word));
        in_take        = !vld_q || out_take;
        out_valid      = vld_q;
        out_term       = term_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            term_q <= '0;
        end else if (clr) begin
            vld_q  <= 1'b0;
        end else if (in_take) begin
            vld_q <= in_valid;
            if (in_valid) term_q <= term_d;
        end
    end

endmodule

// File: rtl/dpa_accum.sv
`timescale 1ns/1ps
module dpa_accum
    import dpa_pkg::*;
#(
    parameter int WORD_W  = 64,
    parameter int N_WORDS = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       new_word,
    input  logic                       in_valid,
    input  term_t                      in_term,
    output logic                       in_take,
    input  logic [$clog2(N_WORDS)-1:0] rd_idx,
    output logic [WORD_W-1:0]          rd_data,
    output logic                       done,
    output acc_st_t                    st_o,
    output logic [N_WORDS-1:0]         pend_o
);

    localparam int IDX_W = $clog2(N_WORDS);
    localparam int OFF_W = $clog2(WORD_W);
    localparam int CH_W  = 2 * WORD_W;

    acc_st_t            st_q, st_d;
    logic [WORD_W-1:0]  mem [N_WORDS];
    logic [N_WORDS-1:0] pend, negf;
    term_t              t_q;
    logic [IDX_W-1:0]   w_q, w1, w2, rk, rk1;
    logic [CH_W-1:0]    chunk_q;
    logic [WORD_W-1:0]  lo_q, hi_q;
    logic [CH_W:0]      res_q;
    logic               ripple, fin_q, done_q;

    assign w1  = w_q + IDX_W'(1);
    assign w2  = w_q + IDX_W'(2);
    assign rk1 = rk + IDX_W'(1);

    // lowest pending flag
    always_comb begin
        rk = '0;
        for (int i = N_WORDS - 1; i >= 0; i--) begin
            if (pend[i]) rk = IDX_W'(i);
        end
        ripple = negf[rk] ? (mem[rk] == '0) : (mem[rk] == '1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st_q <= A_IDLE;
        else if (clr) st_q <= A_IDLE;
        else          st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            A_IDLE: begin
                if (pend != '0)   st_d = A_RESOLVE;
                else if (in_valid) st_d = A_DECODE;
            end
            A_DECODE:  st_d = A_LOAD;
            A_LOAD:    st_d = A_ADDSUB;
            A_ADDSUB:  st_d = A_STORE;
            A_STORE:   st_d = A_IDLE;
            A_RESOLVE: st_d = A_IDLE;
            default:   st_d = A_IDLE;
        endcase
    end

    // datapath and storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < N_WORDS; i++) mem[i] <= '0;
            pend    <= '0;
            negf    <= '0;
            t_q     <= '0;
            w_q     <= '0;
            chunk_q <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            res_q   <= '0;
            fin_q   <= 1'b0;
        end else begin
            unique case (st_q)
                A_IDLE: begin
                    if (pend == '0 && in_valid) t_q <= in_term;
                    if (pend == '0 && fin_q && !in_valid) fin_q <= 1'b0;
                end
                A_DECODE: begin
                    w_q     <= IDX_W'(t_q.shift >> OFF_W);
                    chunk_q <= CH_W'(t_q.prod) << t_q.shift[OFF_W-1:0];
                end
                A_LOAD: begin
                    lo_q <= mem[w_q];
                    hi_q <= mem[w1];
                end
                A_ADDSUB: begin
                    res_q <= t_q.neg ? ({1'b0, hi_q, lo_q} - {1'b0, chunk_q})
                                     : ({1'b0, hi_q, lo_q} + {1'b0, chunk_q});
                end
                A_STORE: begin
                    mem[w_q] <= res_q[WORD_W-1:0];
                    mem[w1]  <= res_q[CH_W-1:WORD_W];
                    if (res_q[CH_W] && (int'(w_q) + 2 < N_WORDS)) begin
                        pend[w2] <= 1'b1;
                        negf[w2] <= t_q.neg;
                    end
                    if (t_q.last) fin_q <= 1'b1;
                end
                A_RESOLVE: begin
                    mem[rk]  <= negf[rk] ? (mem[rk] - WORD_W'(1)) : (mem[rk] + WORD_W'(1));
                    pend[rk] <= 1'b0;
                    if (ripple && (int'(rk) + 1 < N_WORDS)) begin
                        pend[rk1] <= 1'b1;
                        negf[rk1] <= negf[rk];
                    end
                end
                default: ;
            endcase
        end
    end

    // completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 done_q <= 1'b0;
        else if (clr || new_word)   done_q <= 1'b0;
        else if (st_q == A_IDLE && pend == '0 && fin_q && !in_valid)
                                    done_q <= 1'b1;
    end

    // outputs
    always_comb begin
        in_take = (st_q == A_IDLE) && (pend == '0);
        rd_data = (int'(rd_idx) < N_WORDS) ? mem[rd_idx] : '0;
        done    = done_q;
        st_o    = st_q;
        pend_o  = pend;
    end

endmodule

// File: rtl/exact_dot_acc.sv
`timescale 1ns/1ps
module exact_dot_acc
    import dpa_pkg::*;
#(
    parameter int WORD_W  = 64,
    parameter int N_WORDS = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [WORD_W-1:0]          in_data,
    input  logic                       in_last,
    output logic                       done,
    input  logic [$clog2(N_WORDS)-1:0] rd_idx,
    output logic [WORD_W-1:0]          rd_data
);

    logic               pair_valid, pair_last, pair_take;
    logic [FP_W-1:0]    a_word, b_word;
    logic               term_valid, term_take;
    term_t              term;
    logic               new_word;
    acc_st_t            acc_st;
    logic [N_WORDS-1:0] acc_pend;

    assign new_word = in_valid && in_ready;

    dpa_fetch #(.WORD_W(WORD_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .pair_valid (pair_valid),
        .a_word     (a_word),
        .b_word     (b_word),
        .pair_last  (pair_last),
        .pair_take  (pair_take)
    );

    dpa_mulshift u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .in_valid  (pair_valid),
        .a_word    (a_word),
        .b_word    (b_word),
        .in_last   (pair_last),
        .in_take   (pair_take),
        .out_valid (term_valid),
        .out_term  (term),
        .out_take  (term_take)
    );

    dpa_accum #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .new_word (new_word),
        .in_valid (term_valid),
        .in_term  (term),
        .in_take  (term_take),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .done     (done),
        .st_o     (acc_st),
        .pend_o   (acc_pend)
    );

endmodule

// File: rtl/dpa_checker.sv
`timescale 1ns/1ps
module dpa_checker
    import dpa_pkg::*;
#(
    parameter int N_WORDS = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr,
    input logic               in_valid,
    input logic               in_ready,
    input logic               done,
    input acc_st_t            acc_st,
    input logic [N_WORDS-1:0] acc_pend
);

    p_ready_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !clr) |=> !in_ready);

    p_one_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_pend));

    p_done_settled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (acc_pend == '0));

    p_done_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !done);

    p_clr_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!done && acc_pend == '0 && acc_st == A_IDLE));

    p_dec_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_st == A_DECODE && !clr) |=> acc_st == A_LOAD);

    p_load_add_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_st == A_LOAD && !clr) |=> acc_st == A_ADDSUB);

    p_add_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_st == A_ADDSUB && !clr) |=> acc_st == A_STORE);

    p_store_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_st == A_STORE) |=> acc_st == A_IDLE);

endmodule

bind exact_dot_acc dpa_checker #(.N_WORDS(N_WORDS)) u_dpa_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .done     (done),
    .acc_st   (acc_st),
    .acc_pend (acc_pend)
);

// File: tb/exact_dot_acc_bench.sv
`timescale 1ns/1ps
module exact_dot_acc_bench;

    localparam int NW = 10;
    localparam int AW = 64 * NW;
    localparam int NV = 13;

    // {last, A, B}
    localparam logic [64:0] VEC [NV] = '{
        {1'b0, 32'h3F800000, 32'h40000000},
        {1'b0, 32'h40400000, 32'hC0800000},
        {1'b1, 32'h3FC00000, 32'h3FC00000},
        {1'b0, 32'h80800000, 32'h00800000},
        {1'b1, 32'h3F800000, 32'h3F800000},
        {1'b0, 32'h00000000, 32'h7F7FFFFF},
        {1'b0, 32'h007FFFFF, 32'h3F800000},
        {1'b1, 32'h40A00000, 32'h40A00000},
        {1'b0, 32'h7F7FFFFF, 32'h7F7FFFFF},
        {1'b0, 32'h7F7FFFFF, 32'h7F7FFFFF},
        {1'b0, 32'hFF7FFFFF, 32'h7F7FFFFF},
        {1'b0, 32'h00800000, 32'h00800000},
        {1'b1, 32'h3F800000, 32'hBF800000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        done;
    logic [3:0]  rd_idx = '0;
    logic [63:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [AW-1:0] ref_acc = '0;

    always #5 clk = ~clk;

    exact_dot_acc u_exact_dot_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .in_last  (in_last),
        .done     (done),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bench-side model of one term
    task automatic add_ref(input logic [31:0] a, input logic [31:0] b);
        logic [23:0]   ma, mb;
        logic [AW-1:0] t;
        int            sh;
        ma = (a[30:23] == 0) ? 24'd0 : {1'b1, a[22:0]};
        mb = (b[30:23] == 0) ? 24'd0 : {1'b1, b[22:0]};
        sh = int'(a[30:23]) + int'(b[30:23]) - 2;
        if (sh < 0) sh = 0;
        t = AW'(48'(ma) * 48'(mb)) << sh;
        if (a[31] != b[31]) ref_acc = ref_acc - t;
        else                ref_acc = ref_acc + t;
    endtask

    task automatic put(input logic [31:0] w, input logic lst);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = {32'hA5C3_0F96, w};
        in_last  = lst;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
        chk(in_ready == 1'b0, "R2 ready low in decode cycle", 64'(in_ready), 64'd0);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        ref_acc = '0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, req, 64'(done), 64'd1);
    endtask

    task automatic cmp_words(input string req);
        @(negedge clk);
        for (int k = 0; k < NW; k++) begin
            rd_idx = 4'(k);
            #0.5;
            chk(rd_data == ref_acc[64*k +: 64], req, rd_data, ref_acc[64*k +: 64]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int set_no;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);
        chk(done == 1'b0, "R1 done after reset", 64'(done), 64'd0);
        cmp_words("R1 word zero after reset");

        // table walk: R3 R4 R5 R6 sums
        set_no = 0;
        for (int i = 0; i < NV; i++) begin
            add_ref(VEC[i][63:32], VEC[i][31:0]);
            put(VEC[i][63:32], 1'b0);
            put(VEC[i][31:0], VEC[i][64]);
            if (VEC[i][64]) begin
                wait_done("R7 done after last pair");
                cmp_words("R3 R4 R5 R6 exact sum word");
                pulse_clr();
                if (set_no == 0) begin
                    chk(done == 1'b0, "R8 done low after clr", 64'(done), 64'd0);
                    cmp_words("R8 word zero after clr");
                end
                set_no++;
            end
        end

        // R10 latency of a single pair
        add_ref(32'h3F800000, 32'h3F800000);
        put(32'h3F800000, 1'b0);
        put(32'h3F800000, 1'b1);
        n = 0;
        while (!done && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(n == 8, "R10 done latency in negedges", 64'(n), 64'd8);
        cmp_words("R4 R10 single pair sum");

        // R9 out-of-range index
        @(negedge clk);
        rd_idx = 4'd12;
        #0.5;
        chk(rd_data == 64'd0, "R9 index past top reads zero", rd_data, 64'd0);
        rd_idx = 4'd4;
        #0.5;
        chk(rd_data == ref_acc[256 +: 64], "R9 word 4 readout", rd_data, ref_acc[256 +: 64]);

        // R7 done drops on next accepted word
        put(32'h40000000, 1'b0);
        chk(done == 1'b0, "R7 done low after new word", 64'(done), 64'd0);
        pulse_clr();

        // R8 clear while a pair is in flight
        put(32'h7F7FFFFF, 1'b0);
        put(32'h7F7FFFFF, 1'b1);
        pulse_clr();
        repeat (20) @(negedge clk);
        chk(done == 1'b0, "R8 in-flight pair dropped, done low", 64'(done), 64'd0);
        cmp_words("R8 in-flight pair dropped, word zero");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule